// File: doc/BRIEF.md
# Segment Register Address Extender

This block turns a 32-bit effective address into a 52-bit global virtual address. It keeps a small file of sixteen 24-bit segment identifiers, which privileged software loads through a write port. The upper four bits of each effective address pick one identifier. That identifier is placed above the lower 28 bits of the effective address, so each segment spans 256 MB of the global space.

No separate address-space tag is involved. Two processes share a segment when both load the same identifier into one of their segment registers. The top 20 bits of the result carry a fixed marker code that says whether the address is physical, and whether it is cacheable. User-mode requests are confined to the lower half of the effective space. A user request with bit 31 set raises a fault instead of producing an address.

Each request is answered exactly one cycle later on a registered output. The output register has two conditions: it is idle, or it holds either a translation or a fault.

Top module: `segx_extender`

## Requirements
- R1: After reset all sixteen segment identifiers are zero, and `rsp_valid` and `rsp_fault` are low.
- R2: A request with `req_valid` high in cycle N sets `rsp_valid` high in cycle N+1. `rsp_va` then equals the identifier in the register selected by `req_ea[31:28]`, concatenated above `req_ea[27:0]`, with the identifier in bits 51:28.
- R3: A write (`wr_en`, `wr_idx`, `wr_seg`) updates the selected register at the clock edge. A request in the same cycle still sees the old value. Requests from the following cycle on see the new value.
- R4: A request with `req_user` high and `req_ea[31]` high gives `rsp_fault` high and `rsp_valid` low in the next cycle. In that cycle `rsp_va`, `rsp_phys` and `rsp_cache` are all zero.
- R5: A supervisor request (`req_user` low) may use any of the sixteen registers, including 8 to 15, without a fault.
- R6: `rsp_phys` is high exactly when bits 51:32 of the result equal 20'hFFFFF (physical, cached) or 20'hFFFFE (physical, uncached).
- R7: `rsp_cache` is high on every valid result except when bits 51:32 equal 20'hFFFFE.
- R8: Two segment registers that hold the same identifier produce the same global address for the same 28-bit offset.
- R9: A cycle with `req_valid` low leaves `rsp_valid` and `rsp_fault` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a segment register |
| wr_idx | input | 4 | Index of the register to write |
| wr_seg | input | 24 | New segment identifier |
| req_valid | input | 1 | Translation request present |
| req_user | input | 1 | Request is issued in user mode |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Result address is valid |
| rsp_va | output | 52 | Global virtual address |
| rsp_phys | output | 1 | Address is in a physical window |
| rsp_cache | output | 1 | Address may be cached |
| rsp_fault | output | 1 | User request outside the user half |

## Verification
Some properties are checked by assertions on every cycle. These cover:
- the one-cycle answer to each request, and the idle response when no request is present;
- the fault path and its zeroed address and flags;
- the mutual exclusion of valid and fault;
- carrying the offset through unchanged;
- the tie of the uncached flag to a physical window.

Other behaviour only the bench scenarios can show: the content of the register file itself, the clearing at reset, the old-versus-new value when a write meets a request in the same cycle, the exact marker decode, and sharing through equal identifiers. For these the bench compares the outputs against its own model of the register file.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int EA_W     = 32;
    localparam int SEL_W    = 4;
    localparam int SEG_W    = 24;
    localparam int OFF_W    = EA_W - SEL_W;
    localparam int GVA_W    = SEG_W + OFF_W;
    localparam int MARK_W   = 20;
    localparam int NUM_SEGS = 1 << SEL_W;

    localparam logic [MARK_W-1:0] MARK_PHYS_CACHED   = 20'hFFFFF;
    localparam logic [MARK_W-1:0] MARK_PHYS_UNCACHED = 20'hFFFFE;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'b00,
        RSP_XLATE = 2'b01,
        RSP_FAULT = 2'b10
    } rsp_kind_e;

    typedef struct packed {
        logic phys;
        logic cache;
    } region_t;
endpackage

// File: rtl/segx_regfile.sv
module segx_regfile
    import segx_pkg::*;
#(
    parameter int N_SEG  = NUM_SEGS,
    parameter int IDX_W  = SEL_W,
    parameter int DATA_W = SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] seg_q [N_SEG];

    for (genvar i = 0; i < N_SEG; i++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                seg_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = seg_q[rd_idx];
endmodule

// File: rtl/segx_region_decode.sv
module segx_region_decode
    import segx_pkg::*;
#(
    parameter int W = MARK_W,
    parameter logic [W-1:0] CODE_CACHED   = MARK_PHYS_CACHED,
    parameter logic [W-1:0] CODE_UNCACHED = MARK_PHYS_UNCACHED
) (
    input  logic [W-1:0] mark,
    output region_t      region
);
    logic hit_cached;
    logic hit_uncached;

    always_comb begin
        hit_cached    = (mark == CODE_CACHED);
        hit_uncached  = (mark == CODE_UNCACHED);
        region.phys   = hit_cached || hit_uncached;
        region.cache  = !hit_uncached;
    end
endmodule

// File: rtl/segx_extender.sv
module segx_extender
    import segx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_seg,
    input  logic             req_valid,
    input  logic             req_user,
    input  logic [EA_W-1:0]  req_ea,
    output logic             rsp_valid,
    output logic [GVA_W-1:0] rsp_va,
    output logic             rsp_phys,
    output logic             rsp_cache,
    output logic             rsp_fault
);
    logic [SEL_W-1:0] sel;
    logic [SEG_W-1:0] seg_id;
    logic [GVA_W-1:0] gva;
    region_t          region;
    rsp_kind_e        kind_d, kind_q;
    logic [GVA_W-1:0] va_d, va_q;
    region_t          reg_d, reg_q;

    assign sel = req_ea[EA_W-1 -: SEL_W];

    segx_regfile #(.N_SEG(NUM_SEGS), .IDX_W(SEL_W), .DATA_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_seg),
        .rd_idx  (sel),
        .rd_data (seg_id)
    );

    assign gva = {seg_id, req_ea[OFF_W-1:0]};

    segx_region_decode #(.W(MARK_W)) u_region (
        .mark   (gva[GVA_W-1 -: MARK_W]),
        .region (region)
    );

    // next-state selection
    always_comb begin
        kind_d = RSP_IDLE;
        va_d   = '0;
        reg_d  = '0;
        if (req_valid) begin
            if (req_user && req_ea[EA_W-1]) begin
                kind_d = RSP_FAULT;
            end else begin
                kind_d = RSP_XLATE;
                va_d   = gva;
                reg_d  = region;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= RSP_IDLE;
            va_q   <= '0;
            reg_q  <= '0;
        end else begin
            kind_q <= kind_d;
            va_q   <= va_d;
            reg_q  <= reg_d;
        end
    end

    // outputs
    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_va    = '0;
        rsp_phys  = 1'b0;
        rsp_cache = 1'b0;
        unique case (kind_q)
            RSP_IDLE: begin
            end
            RSP_XLATE: begin
                rsp_valid = 1'b1;
                rsp_va    = va_q;
                rsp_phys  = reg_q.phys;
                rsp_cache = reg_q.cache;
            end
            RSP_FAULT: begin
                rsp_fault = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assert_valid_or_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault));

    assert_answer_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_user && req_ea[EA_W-1])) |=> rsp_valid);

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_user && req_ea[EA_W-1])) |=>
            (rsp_va[OFF_W-1:0] == $past(req_ea[OFF_W-1:0])));

    assert_user_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user && req_ea[EA_W-1]) |=>
            (rsp_fault && rsp_va == '0 && !rsp_phys && !rsp_cache));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault));

    assert_uncached_is_phys_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_cache) |-> rsp_phys);

    assert_phys_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_phys |-> rsp_valid);
endmodule

// File: tb/segx_extender_bench.sv
module segx_extender_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [23:0] wr_seg = '0;
    logic        req_valid = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] req_ea = '0;
    logic        rsp_valid;
    logic [51:0] rsp_va;
    logic        rsp_phys;
    logic        rsp_cache;
    logic        rsp_fault;

    int checks = 0;
    int fails = 0;
    logic [23:0] model [16];
    bit done = 1'b0;

    always #5 clk = ~clk;

    segx_extender u_segx_extender (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_seg(wr_seg),
        .req_valid(req_valid), .req_user(req_user), .req_ea(req_ea),
        .rsp_valid(rsp_valid), .rsp_va(rsp_va), .rsp_phys(rsp_phys),
        .rsp_cache(rsp_cache), .rsp_fault(rsp_fault)
    );

    function automatic logic [51:0] exp_va(input logic [23:0] id, input logic [31:0] ea);
        return {id, ea[27:0]};
    endfunction

    function automatic logic exp_phys(input logic [51:0] va);
        return (va[51:32] == 20'hFFFFF) || (va[51:32] == 20'hFFFFE);
    endfunction

    function automatic logic exp_cache(input logic [51:0] va);
        return va[51:32] != 20'hFFFFE;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_seg(input logic [3:0] idx, input logic [23:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_seg = val;
        @(negedge clk);
        wr_en = 1'b0;
        model[idx] = val;
    endtask

    // drive a request, check the answer one cycle later
    task automatic do_req(input string req, input logic user, input logic [31:0] ea);
        logic [51:0] va;
        logic flt;
        @(negedge clk);
        req_valid = 1'b1; req_user = user; req_ea = ea;
        flt = user && ea[31];
        va = flt ? 52'h0 : exp_va(model[ea[31:28]], ea);
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {63'h0, rsp_fault}, {63'h0, flt});
        check(req, {63'h0, rsp_valid}, {63'h0, !flt});
        check(req, {12'h0, rsp_va}, {12'h0, va});
        check(req, {62'h0, rsp_phys, rsp_cache},
              {62'h0, flt ? 2'b00 : {exp_phys(va), exp_cache(va)}});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs and registers
        check("R1 valid", {63'h0, rsp_valid}, 64'h0);
        check("R1 fault", {63'h0, rsp_fault}, 64'h0);
        for (int i = 0; i < 16; i++) do_req("R1 zero reg", 1'b0, {i[3:0], 28'h1234567});

        // R2 / R5: fill registers, supervisor reaches upper ones
        for (int i = 0; i < 16; i++) write_seg(i[3:0], 24'($urandom));
        for (int i = 0; i < 16; i++) do_req("R2 R5 translate", 1'b0, {i[3:0], 28'($urandom)});

        // R4: user requests in upper half fault, lower half translates
        do_req("R4 user fault", 1'b1, 32'h8000_0000);
        do_req("R4 user fault top", 1'b1, 32'hFFFF_FFFF);
        do_req("R2 user low", 1'b1, 32'h7FFF_FFFF);

        // R6 / R7: marker codes
        write_seg(4'd2, 24'hFFFFF3);
        do_req("R6 phys cached", 1'b1, 32'h2ABC_DEF0);
        write_seg(4'd3, 24'hFFFFE7);
        do_req("R7 phys uncached", 1'b1, 32'h3000_0010);
        write_seg(4'd4, 24'hFFFFD0);
        do_req("R6 near miss", 1'b1, 32'h4000_0000);

        // R8: sharing through equal identifiers
        write_seg(4'd5, 24'h13579B);
        write_seg(4'd6, 24'h13579B);
        @(negedge clk);
        req_valid = 1'b1; req_user = 1'b1; req_ea = 32'h5012_3456;
        @(negedge clk);
        req_ea = 32'h6012_3456;
        begin
            logic [51:0] first;
            first = rsp_va;
            @(negedge clk);
            req_valid = 1'b0;
            check("R8 shared", {12'h0, rsp_va}, {12'h0, first});
            check("R8 shared value", {12'h0, first}, {12'h0, 52'h13579B_0123456});
        end

        // R3: write and request in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd7; wr_seg = 24'hA5A5A5;
        req_valid = 1'b1; req_user = 1'b0; req_ea = 32'h7000_0ABC;
        @(negedge clk);
        wr_en = 1'b0;
        check("R3 old value", {12'h0, rsp_va}, {12'h0, exp_va(model[7], 32'h7000_0ABC)});
        model[7] = 24'hA5A5A5;
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 new value", {12'h0, rsp_va}, {12'h0, 52'hA5A5A5_0000ABC});

        // R9: idle cycles produce nothing
        @(negedge clk);
        check("R9 idle valid", {63'h0, rsp_valid}, 64'h0);
        check("R9 idle fault", {63'h0, rsp_fault}, 64'h0);

        // random mix
        for (int n = 0; n < 300; n++) begin
            if ($urandom_range(0, 3) == 0)
                write_seg(4'($urandom), ($urandom_range(0, 3) == 0) ?
                          {20'hFFFFF - 20'($urandom_range(0, 1)), 4'($urandom)} : 24'($urandom));
            do_req("R2 R4 R6 R7 random", 1'($urandom), $urandom);
        end

        // R1 again: reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = '0;
        do_req("R1 after reset", 1'b0, 32'hF123_4567);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule